// File: doc/BRIEF.md
# Serial Link Request Encoder

This block sits on the link-layer side of a serial bus controller. It turns one parallel request into a framed bit stream and drives that stream, one bit per clock, on a single request line toward the physical-layer device. A requester offers a request kind, a speed code, a register address, a data byte for register writes and an acceleration enable. The block takes the request through a valid/ready handshake and shifts out the stream. It raises a one-cycle done pulse on the final bit.

Each stream begins with a high start bit, followed by the three-bit kind code sent most significant bit first. The fields for that kind come next. The stream length depends on the kind: a bus request takes 7 or 8 bits, a register read 9, a register write 17 and an acceleration control 6. A bus request whose last speed bit is zero always omits its stop bit, so it ends on that low speed bit. The line is low between streams. After each stream the block keeps the line low and refuses new work for at least `GAP_CYCLES` clocks. It rejects the reserved kind with an error pulse and does not drive the line.

Top module: `lreq_encoder`

## Requirements
- R1: While `busy` is low, `lreq_out` is 0.
- R2: The first stream bit (bit 0) is 1. Bits 1 to 3 carry `req_kind[2]`, `req_kind[1]`, `req_kind[0]` in that order. Kind codes: 0 immediate, 1 isochronous, 2 priority, 3 fair, 4 register read, 5 register write, 6 acceleration control, 7 reserved.
- R3: For a bus request (kinds 0 to 3), bits 4 to 6 carry `req_speed[2]`, `req_speed[1]`, `req_speed[0]`. When `req_speed[0]` is 0 the stream is 7 bits long. Otherwise an eighth bit of 0 follows. The last bit of every stream is 0.
- R4: Speed codes other than 000, 010 and 100 are framed exactly like valid codes.
- R5: A register read is 9 bits: the header, then `req_addr[3:0]` MSB first in bits 4 to 7, then a stop bit 0.
- R6: A register write is 17 bits: the header, then `req_addr[3:0]` MSB first in bits 4 to 7, then `req_wdata[7:0]` MSB first in bits 8 to 15, then a stop bit 0.
- R7: An acceleration control is 6 bits: the header, then `req_accel` in bit 4, then a stop bit 0.
- R8: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high on exactly the cycles that carry stream bits, starting the cycle after acceptance. `req_ready` is never high while `busy` is.
- R9: `done` is high for exactly one cycle, and that cycle carries the last stream bit.
- R10: Accepting the reserved kind (7) raises `err` for one cycle after the accepting edge. `busy` stays low and the line stays low.
- R11: For `GAP_CYCLES` (default 1) cycles after the last stream bit, `req_ready` and `lreq_out` are low.
- R12: After reset, `lreq_out`, `busy`, `done` and `err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 3 | Request kind code |
| req_speed | input | 3 | Speed code for bus requests |
| req_addr | input | 4 | Register address for read and write |
| req_wdata | input | 8 | Data byte for register write |
| req_accel | input | 1 | Acceleration enable for acceleration control |
| req_ready | output | 1 | Block can take a request this cycle |
| busy | output | 1 | Stream bits are being driven |
| done | output | 1 | Pulse on the last stream bit |
| err | output | 1 | Pulse after a reserved kind was taken |
| lreq_out | output | 1 | Serial request line |

## Verification
The assertions assume that the request fields are stable only on the accepting edge. They assume nothing about the fields at other times, and they assume that `req_valid` may stay high across the gap. The assertions also rely on every legal stream ending low, so a check on the last bit holds for every kind and speed. The stimulus drives fields only at the falling edge. It holds `req_valid` until it sees `req_ready`, which tests waits through the busy and gap periods. It sweeps all kinds, including invalid speed codes and the reserved kind, and it includes back-to-back offers.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
  localparam int KIND_W  = 3;
  localparam int SPEED_W = 3;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + KIND_W + ADDR_W + DATA_W + 1;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [KIND_W-1:0] {
    RQ_IMM   = 3'd0,
    RQ_ISO   = 3'd1,
    RQ_PRI   = 3'd2,
    RQ_FAIR  = 3'd3,
    RQ_RDREG = 3'd4,
    RQ_WRREG = 3'd5,
    RQ_ACCEL = 3'd6,
    RQ_RSVD  = 3'd7
  } rq_kind_e;

  function automatic logic kind_is_bus(input logic [KIND_W-1:0] k);
    return !k[KIND_W-1];
  endfunction

  // Number of bits on the line for one request
  function automatic logic [LEN_W-1:0] frame_len(input logic [KIND_W-1:0] k,
                                                 input logic [SPEED_W-1:0] spd);
    logic [LEN_W-1:0] n;
    case (rq_kind_e'(k))
      RQ_RDREG: n = LEN_W'(1 + KIND_W + ADDR_W + 1);
      RQ_WRREG: n = LEN_W'(FRAME_W);
      RQ_ACCEL: n = LEN_W'(1 + KIND_W + 1 + 1);
      RQ_RSVD:  n = '0;
      default:  n = spd[0] ? LEN_W'(1 + KIND_W + SPEED_W + 1)
                           : LEN_W'(1 + KIND_W + SPEED_W);
    endcase
    return n;
  endfunction

  // Stream packed with bit 0 of the line at the MSB; unused tail stays zero
  function automatic logic [FRAME_W-1:0] frame_bits(input logic [KIND_W-1:0] k,
                                                    input logic [SPEED_W-1:0] spd,
                                                    input logic [ADDR_W-1:0] adr,
                                                    input logic [DATA_W-1:0] dat,
                                                    input logic en);
    logic [FRAME_W-1:0] f;
    localparam int HI = FRAME_W - 1 - 1 - KIND_W;
    f = '0;
    f[FRAME_W-1] = 1'b1;
    f[FRAME_W-2 -: KIND_W] = k;
    case (rq_kind_e'(k))
      RQ_RDREG: f[HI -: ADDR_W] = adr;
      RQ_WRREG: begin
        f[HI -: ADDR_W] = adr;
        f[HI-ADDR_W -: DATA_W] = dat;
      end
      RQ_ACCEL: f[HI] = en;
      RQ_RSVD:  f = '0;
      default:  f[HI -: SPEED_W] = spd;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/lreq_framer.sv
module lreq_framer
  import lreq_pkg::*;
(
  input  logic [KIND_W-1:0]  kind,
  input  logic [SPEED_W-1:0] speed,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               accel,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len,
  output logic               reserved
);
  always_comb begin
    frame    = frame_bits(kind, speed, addr, wdata, accel);
    len      = frame_len(kind, speed);
    reserved = (rq_kind_e'(kind) == RQ_RSVD);
  end
endmodule

// File: rtl/lreq_shifter.sv
module lreq_shifter
  import lreq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  output logic               active,
  output logic               last,
  output logic               bit_out
);
  logic [FRAME_W-1:0] sreg;
  logic [LEN_W-1:0]   left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      left   <= '0;
      active <= 1'b0;
    end else if (load) begin
      sreg   <= frame;
      left   <= len - LEN_W'(1);
      active <= 1'b1;
    end else if (active) begin
      sreg <= {sreg[FRAME_W-2:0], 1'b0};
      if (left == '0) active <= 1'b0;
      else            left   <= left - LEN_W'(1);
    end
  end

  assign last    = active && (left == '0);
  assign bit_out = active && sreg[FRAME_W-1];
endmodule

// File: rtl/lreq_encoder.sv
module lreq_encoder
  import lreq_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic [SPEED_W-1:0] req_speed,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               req_accel,
  output logic               req_ready,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               lreq_out
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               reserved;
  logic               accept;
  logic               load;
  logic               last;
  logic [GAP_W-1:0]   gap_left;

  lreq_framer u_framer (
    .kind     (req_kind),
    .speed    (req_speed),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .accel    (req_accel),
    .frame    (frame),
    .len      (len),
    .reserved (reserved)
  );

  assign accept = req_valid && req_ready;
  assign load   = accept && !reserved;

  lreq_shifter u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .frame   (frame),
    .len     (len),
    .active  (busy),
    .last    (last),
    .bit_out (lreq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_left <= '0;
      err      <= 1'b0;
    end else begin
      err <= accept && reserved;
      if (last)                gap_left <= GAP_W'(GAP_CYCLES);
      else if (gap_left != '0) gap_left <= gap_left - GAP_W'(1);
    end
  end

  assign req_ready = !busy && (gap_left == '0);
  assign done      = last;
endmodule

// File: rtl/lreq_encoder_chk.sv
module lreq_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic err,
  input logic lreq_out
);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lreq_out);
  p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lreq_out);
  p_last_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lreq_out);
  p_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy || err));
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !lreq_out));
  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !req_ready);
endmodule

bind lreq_encoder lreq_encoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .lreq_out  (lreq_out)
);

// File: tb/test_lreq_encoder.sv
module test_lreq_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [2:0] req_speed = '0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_accel = 1'b0;
  logic       req_ready, busy, done, err, lreq_out;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct packed { logic val; logic fin; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  lreq_encoder i_lreq_encoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_speed(req_speed), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_accel(req_accel), .req_ready(req_ready), .busy(busy), .done(done),
    .err(err), .lreq_out(lreq_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Expected stream built bit by bit from the requirements
  task automatic push_stream(input logic [2:0] k, input logic [2:0] s,
                             input logic [3:0] a, input logic [7:0] d, input logic e);
    logic bits[$];
    bits.push_back(1'b1);
    for (int i = 2; i >= 0; i--) bits.push_back(k[i]);
    if (k < 3'd4) begin
      for (int i = 2; i >= 0; i--) bits.push_back(s[i]);
      if (s[0]) bits.push_back(1'b0);
    end else if (k == 3'd6) begin
      bits.push_back(e);
      bits.push_back(1'b0);
    end else begin
      for (int i = 3; i >= 0; i--) bits.push_back(a[i]);
      if (k == 3'd5) for (int i = 7; i >= 0; i--) bits.push_back(d[i]);
      bits.push_back(1'b0);
    end
    foreach (bits[i]) exp_q.push_back('{val: bits[i], fin: (i == bits.size() - 1)});
  endtask

  task automatic send(input logic [2:0] k, input logic [2:0] s,
                      input logic [3:0] a, input logic [7:0] d, input logic e);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_speed = s;
    req_addr = a; req_wdata = d; req_accel = e;
    while (!req_ready) @(negedge clk);
    if (k != 3'd7) push_stream(k, s, a, d, e);
    @(posedge clk);
    #1 req_valid = 1'b0;
    if (k == 3'd7) begin
      @(negedge clk);
      check(err === 1'b1, "R10 err pulse", err, 1);
      check(busy === 1'b0 && lreq_out === 1'b0, "R10 line quiet", lreq_out, 0);
      @(negedge clk);
      check(err === 1'b0, "R10 err one cycle", err, 0);
    end
  endtask

  // Monitor: pops expected bits while busy, watches idle and gap
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_done)
        check(req_ready === 1'b0 && lreq_out === 1'b0, "R11 gap after stream", req_ready, 0);
      if (busy) begin
        check(req_ready === 1'b0, "R8 ready low while busy", req_ready, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 busy without request", 1, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(lreq_out === x.val, "R2-R7 stream bit", lreq_out, x.val);
          check(done === x.fin, "R9 done on last bit", done, x.fin);
        end
      end else begin
        check(lreq_out === 1'b0, "R1 line low when idle", lreq_out, 0);
        check(done === 1'b0, "R9 no done when idle", done, 0);
      end
      prev_done = (done === 1'b1);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lreq_out === 1'b0 && busy === 1'b0, "R12 reset line/busy", lreq_out, 0);
    check(req_ready === 1'b1, "R12 reset ready", req_ready, 1);
    check(done === 1'b0 && err === 1'b0, "R12 reset pulses", err, 0);
    rst_n = 1'b1;
    // R2 R3 bus kinds with valid speeds, shortened form
    for (int k = 0; k < 4; k++) begin
      send(3'(k), 3'b000, 4'h0, 8'h00, 1'b0);
      send(3'(k), 3'b010, 4'h0, 8'h00, 1'b0);
      send(3'(k), 3'b100, 4'h0, 8'h00, 1'b0);
    end
    // R4 invalid speeds, including 8-bit forms
    send(3'd0, 3'b001, 4'h0, 8'h00, 1'b0);
    send(3'd3, 3'b111, 4'h0, 8'h00, 1'b0);
    send(3'd1, 3'b110, 4'h0, 8'h00, 1'b0);
    send(3'd2, 3'b011, 4'h0, 8'h00, 1'b0);
    // R5 reads
    send(3'd4, 3'b000, 4'h0, 8'h00, 1'b0);
    send(3'd4, 3'b000, 4'hF, 8'h00, 1'b0);
    send(3'd4, 3'b000, 4'hA, 8'h00, 1'b0);
    // R6 writes
    send(3'd5, 3'b000, 4'h5, 8'hC3, 1'b0);
    send(3'd5, 3'b000, 4'hF, 8'hFF, 1'b0);
    send(3'd5, 3'b000, 4'h8, 8'h01, 1'b0);
    // R7 acceleration
    send(3'd6, 3'b000, 4'h0, 8'h00, 1'b1);
    send(3'd6, 3'b000, 4'h0, 8'h00, 1'b0);
    // R10 reserved, then normal traffic resumes
    send(3'd7, 3'b100, 4'hF, 8'hFF, 1'b1);
    send(3'd2, 3'b100, 4'h0, 8'h00, 1'b0);
    // R8 R11 back-to-back offers
    for (int i = 0; i < 6; i++) send(3'(i % 7), 3'(i), 4'(i * 3), 8'(i * 37), i[0]);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R8 all streams sent", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule